// File: doc/BRIEF.md
# Programmable-Threshold Synchronous FIFO

This block is a single-clock first-in first-out buffer. Its depth and data width are parameters. It reports five registered status outputs, all active low: an empty indicator, a full indicator, a half-full indicator, and two warning levels, almost-empty and almost-full. Each warning level is set by its own offset register.

Two straps are sampled while the synchronous reset is high. The first is `ofs_ld`. Held high, it selects serial offset loading: one bit enters per cycle on `ser_in` while `ser_en` is high, and both offsets reset to 1023. Held low, it selects parallel loading: in normal operation, `ofs_ld` then acts as a strobe that redirects a write or a read on the data bus to the offset registers, and both offsets reset to 127. The second strap is `strap_fwft`, which selects fall-through mode. In that mode an output stage holds the oldest word on `rd_data` before it is read. The capacity grows by one word, and every threshold moves up by one word.

In fall-through mode the empty and full pins change meaning. The empty pin becomes an output-ready indicator and the full pin becomes an input-ready indicator, each low when ready.

Top module: `pflag_fifo`

## Requirements
- R1: The level of `ofs_ld` while `rst` is high picks serial offset loading (1) or parallel offset loading (0). The level of `strap_fwft` while `rst` is high picks fall-through mode (1) or standard mode (0). Both choices hold until the next reset.
- R2: After a reset with serial loading, both offsets equal 1023.
- R3: After a reset with parallel loading, both offsets equal 127.
- R4: A write is accepted only while the stored count is below capacity, and a read only while the FIFO holds a readable word. Rejected operations change neither the count nor the contents. An accepted read together with an accepted write leaves the count unchanged.
- R5: Words leave in the order they were written. In standard mode a read accepted at an edge presents its word on `rd_data` after that edge.
- R6: In standard mode, with count c, empty offset n and full offset m, the outputs are low under these conditions:
  - `empty_or_n` when c = 0;
  - `full_ir_n` when c = DEPTH;
  - `almost_empty_n` when c ≤ n;
  - `almost_full_n` when c ≥ DEPTH−m;
  - `half_full_n` when c ≥ DEPTH/2+1.
- R7: In fall-through mode the capacity is DEPTH+1. `almost_empty_n` is low for c ≤ n+1, `almost_full_n` is low for c ≥ DEPTH+1−m and `half_full_n` is low for c ≥ DEPTH/2+2. `full_ir_n` is low (input ready) while c < DEPTH+1 and high at c = DEPTH+1.
- R8: In fall-through mode `empty_or_n` is low while the oldest word is shown on `rd_data`. A word written into an empty FIFO becomes ready after the second rising edge. A read while `empty_or_n` is high is ignored.
- R9: In serial mode, each cycle with `ser_en` high shifts `ser_in`, least significant bit first:
  - bits 0..OFF_W−1 go into the empty offset;
  - the next OFF_W bits go into the full offset;
  - the sequence then wraps back to the empty offset.
  `ser_en` has no effect in parallel mode.
- R10: In parallel mode, `ofs_ld` with `wr_en` stores `wr_data[OFF_W-1:0]` into the empty offset, then into the full offset on the next such strobe, alternating, with no FIFO write. In serial mode the same combination is an ordinary FIFO write.
- R11: In parallel mode, `ofs_ld` with `rd_en` shows the empty offset, then the full offset, alternating, zero-extended on `rd_data` for the one cycle after the edge, with no FIFO read. In serial mode the same combination is an ordinary FIFO read.
- R12: All status outputs are registered and change on the edge that changes the count. Reset empties the FIFO and drives the outputs as follows:
  - `almost_empty_n` low;
  - `almost_full_n` and `half_full_n` high;
  - in standard mode, `empty_or_n` low and `full_ir_n` high;
  - in fall-through mode, `empty_or_n` high and `full_ir_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are sampled while it is high |
| strap_fwft | input | 1 | Fall-through mode strap |
| ofs_ld | input | 1 | Loading-method strap during reset; offset strobe in parallel mode |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write data, and the offset value for parallel loading |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read data, or an offset value during readback |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset data bit |
| empty_or_n | output | 1 | Empty (standard mode) or output ready (fall-through mode), active low |
| full_ir_n | output | 1 | Full (standard mode) or input ready (fall-through mode), active low |
| almost_empty_n | output | 1 | Almost-empty warning, active low |
| almost_full_n | output | 1 | Almost-full warning, active low |
| half_full_n | output | 1 | Half-full warning, active low |

## Verification
The assertions take for granted that the straps are settled during reset. They also assume that a full offset never exceeds DEPTH−1, and that reset is held for at least two edges before `$past` is consulted. The bench programs only full offsets below the depth and holds reset for three cycles. In fall-through mode it issues reads only once the output stage has had a cycle to load. That way its count model can treat a read as accepted exactly when the count is nonzero.

// File: rtl/pflag_pkg.sv
`timescale 1ns/1ps
package pflag_pkg;
  // Mode captured from the straps during reset.
  typedef struct packed {
    logic par;   // 1: parallel offset loading
    logic fwft;  // 1: fall-through read stage
  } pf_mode_t;
endpackage

// File: rtl/pf_ofs_regs.sv
`timescale 1ns/1ps
module pf_ofs_regs #(
  parameter int OFF_W   = 10,
  parameter int SER_DEF = 1023,
  parameter int PAR_DEF = 127
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_strap,
  input  logic             ser_en,
  input  logic             ser_in,
  input  logic             ofs_wr,
  input  logic             ofs_rd,
  input  logic [OFF_W-1:0] wdat,
  output logic             par_mode,
  output logic [OFF_W-1:0] ae_ofs,
  output logic [OFF_W-1:0] af_ofs,
  output logic [OFF_W-1:0] rb_val,
  output logic             rb_show
);
  localparam int SIW = $clog2(2 * OFF_W);
  localparam logic [SIW-1:0] SLAST = SIW'(2 * OFF_W - 1);
  localparam logic [OFF_W-1:0] SER_V = OFF_W'(SER_DEF);
  localparam logic [OFF_W-1:0] PAR_V = OFF_W'(PAR_DEF);

  logic [SIW-1:0] sidx;
  logic           wsel, rsel;

  always_ff @(posedge clk) begin
    if (rst) begin
      par_mode <= ~ld_strap;
      ae_ofs   <= ld_strap ? SER_V : PAR_V;
      af_ofs   <= ld_strap ? SER_V : PAR_V;
      sidx     <= '0;
      wsel     <= 1'b0;
      rsel     <= 1'b0;
      rb_show  <= 1'b0;
      rb_val   <= '0;
    end else begin
      // serial path: low half of the index targets the empty offset
      if (!par_mode && ser_en) begin
        for (int i = 0; i < OFF_W; i++) begin
          if (sidx == SIW'(i))         ae_ofs[i] <= ser_in;
          if (sidx == SIW'(i + OFF_W)) af_ofs[i] <= ser_in;
        end
        sidx <= (sidx == SLAST) ? '0 : sidx + 1'b1;
      end
      // parallel path
      if (ofs_wr) begin
        if (!wsel) ae_ofs <= wdat;
        else       af_ofs <= wdat;
        wsel <= ~wsel;
      end
      rb_show <= ofs_rd;
      if (ofs_rd) begin
        rb_val <= rsel ? af_ofs : ae_ofs;
        rsel   <= ~rsel;
      end
    end
  end

  // R1
  mode_stable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(par_mode));

  // R9
  ser_onebit_chk: assert property (@(posedge clk) disable iff (rst)
    !par_mode |=> ($countones(ae_ofs ^ $past(ae_ofs)) +
                   $countones(af_ofs ^ $past(af_ofs))) <= 1);

  // R10
  par_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (par_mode && ofs_wr && !wsel) |=> ae_ofs == $past(wdat));
endmodule

// File: rtl/pf_store.sv
`timescale 1ns/1ps
module pf_store #(
  parameter int DATA_W = 18,
  parameter int DEPTH  = 1024,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwft,
  input  logic              wr_req,
  input  logic              rd_req,
  input  logic [DATA_W-1:0] wdat,
  output logic [DATA_W-1:0] dout,
  output logic [CNT_W-1:0]  cnt_nx,
  output logic              ov_nx
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CNT_W-1:0] CAP_STD = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CAP_FT  = CNT_W'(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic [CNT_W-1:0]  cnt_q, cap, mcnt;
  logic              ov_q, wr_acc, rd_acc, pop;

  always_comb begin
    cap    = fwft ? CAP_FT : CAP_STD;
    wr_acc = !rst && wr_req && (cnt_q != cap);
    rd_acc = !rst && rd_req && (fwft ? ov_q : (cnt_q != '0));
    mcnt   = cnt_q - CNT_W'(ov_q);
    // words leave storage on a read (standard) or to refill the output stage
    pop    = fwft ? (!rst && (mcnt != '0) && (!ov_q || rd_acc)) : rd_acc;
    if (!fwft)       ov_nx = 1'b0;
    else if (pop)    ov_nx = 1'b1;
    else if (rd_acc) ov_nx = 1'b0;
    else             ov_nx = ov_q;
    cnt_nx = cnt_q + CNT_W'(wr_acc) - CNT_W'(rd_acc);
  end

  // storage without reset, synchronous read-first port
  always_ff @(posedge clk) begin
    if (wr_acc) mem[wptr] <= wdat;
    if (pop)    dout      <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      wptr  <= '0;
      rptr  <= '0;
      ov_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_nx;
      ov_q  <= ov_nx;
      if (wr_acc) wptr <= wptr + 1'b1;
      if (pop)    rptr <= rptr + 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= cap);

  // R4
  rd_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && rd_req && !wr_req) |=> cnt_q == '0);

  // R4
  rw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fwft && cnt_q != '0 && cnt_q != cap && wr_req && rd_req) |=> $stable(cnt_q));

  // R8
  ready_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    ov_q |-> cnt_q != '0);
endmodule

// File: rtl/pf_flags.sv
`timescale 1ns/1ps
module pf_flags #(
  parameter int DEPTH = 1024,
  parameter int OFF_W = 10,
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fwft_strap,
  input  logic             fwft,
  input  logic [CNT_W-1:0] cnt_nx,
  input  logic             ov_nx,
  input  logic [OFF_W-1:0] ae_ofs,
  input  logic [OFF_W-1:0] af_ofs,
  output logic             empty_or_n,
  output logic             full_ir_n,
  output logic             almost_empty_n,
  output logic             almost_full_n,
  output logic             half_full_n
);
  localparam int CW1 = CNT_W + 1;

  logic [CW1-1:0] c, ae_lim, af_lim, hf_lim, f_lim;

  always_comb begin
    c      = CW1'(cnt_nx);
    ae_lim = CW1'(ae_ofs) + CW1'(fwft);
    af_lim = CW1'(DEPTH) + CW1'(fwft) - CW1'(af_ofs);
    hf_lim = CW1'(DEPTH / 2 + 1) + CW1'(fwft);
    f_lim  = CW1'(DEPTH) + CW1'(fwft);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_or_n     <= fwft_strap;
      full_ir_n      <= ~fwft_strap;
      almost_empty_n <= 1'b0;
      almost_full_n  <= 1'b1;
      half_full_n    <= 1'b1;
    end else begin
      empty_or_n     <= fwft ? ~ov_nx : (c != '0);
      full_ir_n      <= fwft ? (c == f_lim) : (c != f_lim);
      almost_empty_n <= ~(c <= ae_lim);
      almost_full_n  <= ~(c >= af_lim);
      half_full_n    <= ~(c >= hf_lim);
    end
  end

  // R6
  full_af_chk: assert property (@(posedge clk) disable iff (rst)
    (!fwft && !full_ir_n) |-> (!almost_full_n && !half_full_n));

  // R7
  ft_full_af_chk: assert property (@(posedge clk) disable iff (rst)
    (fwft && full_ir_n) |-> (!almost_full_n && !half_full_n));

  // R12
  hf_leaves_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (!fwft && !half_full_n) |-> empty_or_n);
endmodule

// File: rtl/pflag_fifo.sv
`timescale 1ns/1ps
module pflag_fifo #(
  parameter int DATA_W  = 18,
  parameter int DEPTH   = 1024,
  parameter int SER_DEF = 1023,
  parameter int PAR_DEF = 127
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_fwft,
  input  logic              ofs_ld,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ser_en,
  input  logic              ser_in,
  output logic              empty_or_n,
  output logic              full_ir_n,
  output logic              almost_empty_n,
  output logic              almost_full_n,
  output logic              half_full_n
);
  import pflag_pkg::*;

  localparam int OFF_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 2);

  pf_mode_t          mode;
  logic              fwft_q;
  logic              ofs_hit, ofs_wr, ofs_rd, wr_req, rd_req, rb_show, ov_nx;
  logic [OFF_W-1:0]  ae_ofs, af_ofs, rb_val;
  logic [CNT_W-1:0]  cnt_nx;
  logic [DATA_W-1:0] dout;

  always_ff @(posedge clk) begin
    if (rst) fwft_q <= strap_fwft;
  end

  always_comb begin
    mode.fwft = fwft_q;
    ofs_hit   = mode.par && ofs_ld;
    ofs_wr    = !rst && ofs_hit && wr_en;
    ofs_rd    = !rst && ofs_hit && rd_en;
    wr_req    = wr_en && !ofs_hit;
    rd_req    = rd_en && !ofs_hit;
    rd_data   = rb_show ? DATA_W'(rb_val) : dout;
  end

  pf_ofs_regs #(.OFF_W(OFF_W), .SER_DEF(SER_DEF), .PAR_DEF(PAR_DEF)) u_ofs (
    .clk(clk), .rst(rst), .ld_strap(ofs_ld), .ser_en(ser_en), .ser_in(ser_in),
    .ofs_wr(ofs_wr), .ofs_rd(ofs_rd), .wdat(wr_data[OFF_W-1:0]),
    .par_mode(mode.par), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .rb_val(rb_val), .rb_show(rb_show));

  pf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_store (
    .clk(clk), .rst(rst), .fwft(mode.fwft), .wr_req(wr_req), .rd_req(rd_req),
    .wdat(wr_data), .dout(dout), .cnt_nx(cnt_nx), .ov_nx(ov_nx));

  pf_flags #(.DEPTH(DEPTH), .OFF_W(OFF_W), .CNT_W(CNT_W)) u_flags (
    .clk(clk), .rst(rst), .fwft_strap(strap_fwft), .fwft(mode.fwft),
    .cnt_nx(cnt_nx), .ov_nx(ov_nx), .ae_ofs(ae_ofs), .af_ofs(af_ofs),
    .empty_or_n(empty_or_n), .full_ir_n(full_ir_n),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
    .half_full_n(half_full_n));

  // R11
  rb_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (rb_show && !ofs_rd) |=> !rb_show);
endmodule

// File: tb/pflag_fifo_tb.sv
`timescale 1ns/1ps
module pflag_fifo_tb;
  localparam int DW = 18;
  localparam int D  = 1024;
  localparam int NV = 20;

  // {wr, rd, repeats[11:0], {empty_or_n, full_ir_n, ae_n, af_n, hf_n}} standard mode, n=m=127
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 12'd127, 5'b11011}, {1'b1, 1'b0, 12'd1,   5'b11111},
    {1'b1, 1'b0, 12'd384, 5'b11111}, {1'b1, 1'b0, 12'd1,   5'b11110},
    {1'b1, 1'b0, 12'd383, 5'b11110}, {1'b1, 1'b0, 12'd1,   5'b11100},
    {1'b1, 1'b0, 12'd126, 5'b11100}, {1'b1, 1'b0, 12'd1,   5'b10100},
    {1'b1, 1'b0, 12'd3,   5'b10100}, {1'b1, 1'b1, 12'd5,   5'b11100},
    {1'b0, 1'b1, 12'd126, 5'b11100}, {1'b0, 1'b1, 12'd1,   5'b11110},
    {1'b0, 1'b1, 12'd383, 5'b11110}, {1'b0, 1'b1, 12'd1,   5'b11111},
    {1'b0, 1'b1, 12'd384, 5'b11111}, {1'b0, 1'b1, 12'd1,   5'b11011},
    {1'b0, 1'b1, 12'd127, 5'b01011}, {1'b0, 1'b1, 12'd2,   5'b01011},
    {1'b1, 1'b1, 12'd4,   5'b11011}, {1'b0, 1'b1, 12'd1,   5'b01011}
  };

  logic clk = 1'b0;
  logic rst = 1'b1, strap_fwft = 1'b0, ofs_ld = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic ser_en = 1'b0, ser_in = 1'b0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic empty_or_n, full_ir_n, almost_empty_n, almost_full_n, half_full_n;

  int checks = 0, fails = 0;
  int cnt = 0, k = 0, n = 127, m = 127;
  logic par = 1'b1;
  logic [DW-1:0] mq[$];
  logic [DW-1:0] dseq = 18'h100;

  always #10 clk = ~clk;

  pflag_fifo u_dut (
    .clk(clk), .rst(rst), .strap_fwft(strap_fwft), .ofs_ld(ofs_ld),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ser_en(ser_en), .ser_in(ser_in), .empty_or_n(empty_or_n),
    .full_ir_n(full_ir_n), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .half_full_n(half_full_n));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_flags();
    string t;
    t = (k == 1) ? "R7" : "R6";
    if (k == 0) chk({t, " empty"}, 32'(empty_or_n), 32'(cnt != 0));
    chk({t, " full/ready"}, 32'(full_ir_n), (k == 1) ? 32'(cnt == D + 1) : 32'(cnt != D));
    chk({t, " almost_empty"}, 32'(almost_empty_n), 32'(!(cnt <= n + k)));
    chk({t, " almost_full"}, 32'(almost_full_n), 32'(!(cnt >= D + k - m)));
    chk({t, " half_full"}, 32'(half_full_n), 32'(!(cnt >= D / 2 + 1 + k)));
  endtask

  // one cycle of stimulus, called and returning at a falling edge
  task automatic op(input logic w, input logic r, input logic l, input logic [DW-1:0] d);
    logic wacc, racc;
    logic [DW-1:0] hd;
    if (k == 1 && r && !(par && l) && cnt > 0) chk("R8 head", 32'(rd_data), 32'(mq[0]));
    wr_en = w; rd_en = r; ofs_ld = l; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; ofs_ld = 1'b0;
    wacc = w && !(par && l) && (cnt != D + k);
    racc = r && !(par && l) && (cnt != 0);
    if (racc) begin
      hd = mq.pop_front();
      if (k == 0) chk("R5 data", 32'(rd_data), 32'(hd));
    end
    if (wacc) mq.push_back(d);
    cnt = cnt + int'(wacc) - int'(racc);
    chk_flags();
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) @(negedge clk);
  endtask

  task automatic rb(input string tag, input int exp);
    ofs_ld = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    ofs_ld = 1'b0; rd_en = 1'b0;
    chk(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic shift(input int bits, input logic [19:0] v);
    for (int i = 0; i < bits; i++) begin
      ser_en = 1'b1; ser_in = v[i];
      @(negedge clk);
    end
    ser_en = 1'b0; ser_in = 1'b0;
  endtask

  task automatic do_reset(input logic ldv, input logic fw);
    rst = 1'b1; ofs_ld = ldv; strap_fwft = fw;
    idle(3);
    rst = 1'b0; ofs_ld = 1'b0; strap_fwft = 1'b0;
    cnt = 0; mq.delete(); k = int'(fw); par = ~ldv;
    n = ldv ? 1023 : 127; m = n;
    // R12 reset state
    chk("R12 empty", 32'(empty_or_n), 32'(fw));
    chk("R12 full", 32'(full_ir_n), 32'(!fw));
    chk("R12 almost_empty", 32'(almost_empty_n), 32'd0);
    chk("R12 almost_full", 32'(almost_full_n), 32'd1);
    chk("R12 half_full", 32'(half_full_n), 32'd1);
  endtask

  task automatic put(input int num);
    for (int i = 0; i < num; i++) begin op(1'b1, 1'b0, 1'b0, dseq); dseq++; end
  endtask

  task automatic take(input int num);
    for (int i = 0; i < num; i++) op(1'b0, 1'b1, 1'b0, '0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    // parallel loading, standard mode (R1, R3)
    do_reset(1'b0, 1'b0);
    rb("R3 empty ofs", 127);
    rb("R3 full ofs", 127);

    // table walk: R4, R5, R6 boundaries
    for (int i = 0; i < NV; i++) begin
      for (int j = 0; j < int'(VEC[i][16:5]); j++) begin
        op(VEC[i][18], VEC[i][17], 1'b0, dseq);
        dseq++;
      end
      chk("R6 table flags", 32'({empty_or_n, full_ir_n, almost_empty_n, almost_full_n, half_full_n}),
          32'(VEC[i][4:0]));
    end
    take(1);

    // R10 parallel offset writes, no FIFO write
    op(1'b1, 1'b0, 1'b1, 18'd5);
    op(1'b1, 1'b0, 1'b1, 18'd10);
    n = 5; m = 10;
    chk("R10 no fifo write", 32'(empty_or_n), 32'd0);
    rb("R11 empty ofs", 5);
    rb("R11 full ofs", 10);
    put(5);
    chk("R10 ae at n", 32'(almost_empty_n), 32'd0);
    put(1);
    chk("R10 ae above n", 32'(almost_empty_n), 32'd1);
    // R9 serial enable ignored in parallel mode
    shift(20, 20'hFFFFF);
    rb("R9 ignored ae", 5);
    rb("R9 ignored af", 10);
    take(6);

    // serial loading (R1, R2)
    do_reset(1'b1, 1'b0);
    put(1);
    chk("R2 af default", 32'(almost_full_n), 32'd0);
    chk("R2 ae default", 32'(almost_empty_n), 32'd0);
    // R11 strobe with read is a normal read in serial mode
    op(1'b0, 1'b1, 1'b1, '0);
    chk("R11 serial normal read", 32'(empty_or_n), 32'd0);
    // R9 serial shift: ae=3, af=1020, LSB first
    shift(20, {10'd1020, 10'd3});
    n = 3; m = 1020;
    put(2);
    // R10 strobe with write is a normal write in serial mode
    op(1'b1, 1'b0, 1'b1, dseq); dseq++;
    chk("R9 ae at 3", 32'(almost_empty_n), 32'd0);
    chk("R9 af below 4", 32'(almost_full_n), 32'd1);
    put(1);
    chk("R9 ae at 4", 32'(almost_empty_n), 32'd1);
    chk("R9 af at 4", 32'(almost_full_n), 32'd0);
    take(4);
    // R9 wrap: next 10 bits land in the empty offset again
    shift(10, {10'd0, 10'd2});
    n = 2;
    put(2);
    chk("R9 wrap ae at 2", 32'(almost_empty_n), 32'd0);
    put(1);
    chk("R9 wrap ae at 3", 32'(almost_empty_n), 32'd1);
    take(3);

    // fall-through mode, parallel loading (R7, R8)
    do_reset(1'b0, 1'b1);
    op(1'b1, 1'b0, 1'b0, 18'h2A5A5);
    chk("R8 not ready after first edge", 32'(empty_or_n), 32'd1);
    idle(1);
    chk("R8 ready after second edge", 32'(empty_or_n), 32'd0);
    chk("R8 word shown", 32'(rd_data), 32'h2A5A5);
    take(1);
    chk("R8 drained", 32'(empty_or_n), 32'd1);
    take(1);
    chk("R8 read when not ready ignored", 32'(full_ir_n), 32'd0);
    put(D + 3);
    chk("R7 full at DEPTH+1", 32'(full_ir_n), 32'd1);
    idle(2);
    take(D + 1);
    idle(1);
    chk("R8 empty after drain", 32'(empty_or_n), 32'd1);
    chk("R4 count back to zero", 32'(almost_empty_n), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule